// File: doc/BRIEF.md
# Live Probe State Reporter

This block watches a set of digital probe pins all the time and answers a short host request with one status byte for each probe. Every byte carries the probe number, the present level, and two flags that tell whether the level rose or fell since the previous reply. The flags compare against the last level sent to the host, not against the level one clock earlier. A host that polls slowly therefore still sees every net change, one poll at a time.

The host writes bytes on a valid/ready input stream. The request is the header 0x19 followed by an argument byte with bit 7 set. When the argument byte is accepted, all probe levels are captured together in one cycle. The reply then goes out on a valid/ready output stream in ascending probe order. Probe pins pass through a synchroniser before they are captured.

Top module: `probe_state_reporter`

## Requirements
- R1: A reply is started only by an accepted 0x19 followed directly by an accepted byte with bit 7 set. A second 0x19 in the argument position keeps the parser waiting for the argument. Any other argument byte (bit 7 clear) drops the request without a reply, and a byte with bit 7 set that does not follow 0x19 starts nothing.
- R2: A reply is exactly NUM_PROBES bytes with probe indices 0, 1, ... NUM_PROBES-1 in order, whatever the value in bits 6..0 of the argument byte. tx_valid is low in the cycle after the last byte is taken.
- R3: The probe index sits in the top bits of each reply byte: bits 7..3 when NUM_PROBES is 17 to 32, bits 7..4 when it is 16 or fewer. Any bits between the index field and bit 2 are zero.
- R4: Bit 0 of a reply byte is the captured level of that probe.
- R5: Bit 1 is set when the previously reported level was 0 and the captured level is 1.
- R6: Bit 2 is set when the previously reported level was 1 and the captured level is 0. After reset every previously reported level counts as 0.
- R7: All levels are captured in the single clock edge that follows acceptance of the argument byte. Probe changes after that edge do not appear in the reply.
- R8: The stored previously reported levels take the captured values once the final reply byte has been taken, so the next reply compares against them.
- R9: Each probe passes through two register stages. A change that is applied before the clock edge that accepts the header byte appears in the capture. A change applied only before the edge that accepts the argument byte does not appear.
- R10: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R11: rx_ready is low from the edge that accepts the argument byte until the reply ends. Bytes offered in that time are not taken and start no later reply.
- R12: After reset tx_valid is 0 and rx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_in | input | NUM_PROBES | Asynchronous probe pins |
| rx_valid | input | 1 | Host byte offered |
| rx_ready | output | 1 | Block can take a host byte |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Reply byte offered |
| tx_ready | input | 1 | Host takes the reply byte |
| tx_data | output | 8 | Reply byte |

## Verification
The argument byte is accepted at edge A. The capture and tx_valid follow at edge A+1. Each taken reply byte moves the index on at that same edge. tx_valid goes low at the edge that takes the last byte. A probe change has to reach the pins before the edge that accepts the header byte to be part of the capture. The bench drives and samples on the falling edge only. It compares a byte only in a cycle where the handshake will take it. It checks that tx_valid is low one falling edge after the last byte. The synchroniser test places a probe change one cycle on each side of the two-stage limit.

// File: rtl/probe_rpt_pkg.sv
package probe_rpt_pkg;
   localparam logic [7:0] REQ_HEADER = 8'h19;

   // width of the index field at the top of a reply byte
   function automatic int unsigned reply_idx_width(input int unsigned n);
      return ($clog2(n) < 4) ? 4 : $clog2(n);
   endfunction

   typedef enum logic [0:0] {
      PS_HEADER = 1'b0,
      PS_ARG    = 1'b1
   } parse_state_e;
endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
   parameter int WIDTH  = 18,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/probe_req_parser.sv
module probe_req_parser
   import probe_rpt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] byte_in,
   output logic       req
);
   parse_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PS_HEADER;
         req     <= 1'b0;
      end else begin
         req <= 1'b0;
         if (accept) begin
            unique case (state_q)
               PS_HEADER: if (byte_in == REQ_HEADER) state_q <= PS_ARG;
               PS_ARG: begin
                  if (byte_in[7]) begin
                     req     <= 1'b1;
                     state_q <= PS_HEADER;
                  end else if (byte_in != REQ_HEADER) begin
                     state_q <= PS_HEADER;
                  end
               end
               default: state_q <= PS_HEADER;
            endcase
         end
      end
   end
endmodule

// File: rtl/probe_reply_engine.sv
module probe_reply_engine
   import probe_rpt_pkg::*;
#(
   parameter int NUM_PROBES = 18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic [NUM_PROBES-1:0] levels,
   input  logic                  tx_ready,
   output logic                  tx_valid,
   output logic [7:0]            tx_data,
   output logic                  busy
);
   localparam int IDX_W = reply_idx_width(NUM_PROBES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PROBES - 1);

   logic [NUM_PROBES-1:0] snap_q;
   logic [NUM_PROBES-1:0] shown_q;
   logic [IDX_W-1:0]      idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx_q   <= '0;
         snap_q  <= '0;
         shown_q <= '0;
      end else if (req && !busy) begin
         snap_q <= levels;
         idx_q  <= '0;
         busy   <= 1'b1;
      end else if (busy && tx_ready) begin
         if (idx_q == LAST_IDX) begin
            busy    <= 1'b0;
            shown_q <= snap_q;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   logic now_lvl, was_lvl;
   always_comb begin
      now_lvl            = snap_q[idx_q];
      was_lvl            = shown_q[idx_q];
      tx_data            = '0;
      tx_data[7 -: IDX_W] = idx_q;
      tx_data[2]         = was_lvl & ~now_lvl;
      tx_data[1]         = ~was_lvl & now_lvl;
      tx_data[0]         = now_lvl;
   end

   assign tx_valid = busy;
endmodule

// File: rtl/probe_state_reporter.sv
module probe_state_reporter
   import probe_rpt_pkg::*;
#(
   parameter int NUM_PROBES  = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PROBES-1:0] probe_in,
   input  logic                  rx_valid,
   output logic                  rx_ready,
   input  logic [7:0]            rx_data,
   output logic                  tx_valid,
   input  logic                  tx_ready,
   output logic [7:0]            tx_data
);
   if (NUM_PROBES < 1 || NUM_PROBES > 32) begin : g_bad_count
      $error("NUM_PROBES must lie in 1..32 so the index fits above the flag bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PROBES-1:0] levels;
   logic                  req;
   logic                  busy;

   probe_sync #(.WIDTH(NUM_PROBES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (probe_in),
      .q_sync  (levels)
   );

   assign rx_ready = ~(busy | req);

   probe_req_parser u_parser (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (rx_valid & rx_ready),
      .byte_in (rx_data),
      .req     (req)
   );

   probe_reply_engine #(.NUM_PROBES(NUM_PROBES)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .levels   (levels),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .busy     (busy)
   );
endmodule

// File: rtl/probe_state_reporter_chk.sv
module probe_state_reporter_chk
   import probe_rpt_pkg::*;
#(
   parameter int NUM_PROBES = 18
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_ready,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data
);
   localparam int IDX_W = reply_idx_width(NUM_PROBES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PROBES - 1);

   logic [IDX_W-1:0] cur_idx;
   assign cur_idx = tx_data[7 -: IDX_W];

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   // R11
   rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);

   // R2
   first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> cur_idx == '0);

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && cur_idx != LAST_IDX |=>
         tx_valid && cur_idx == $past(cur_idx) + 1'b1);

   // R2
   reply_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && cur_idx == LAST_IDX |=> !tx_valid);

   // R5
   rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_data[1] |-> tx_data[0] && !tx_data[2]);

   // R6
   fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_data[2] |-> !tx_data[0] && !tx_data[1]);
endmodule

bind probe_state_reporter probe_state_reporter_chk #(.NUM_PROBES(NUM_PROBES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_ready (rx_ready),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_data  (tx_data)
);

// File: tb/tb_probe_state_reporter.sv
module tb_probe_state_reporter;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 18;
   localparam int IW = ($clog2(N) < 4) ? 4 : $clog2(N);
   localparam int SH = 8 - IW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] probes = '0;
   logic         rx_valid = 1'b0;
   logic [7:0]   rx_data = '0;
   logic         rx_ready;
   logic         tx_valid;
   logic         tx_ready = 1'b0;
   logic [7:0]   tx_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [N-1:0] last_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   probe_state_reporter #(.NUM_PROBES(N)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .probe_in (probes),
      .rx_valid (rx_valid),
      .rx_ready (rx_ready),
      .rx_data  (rx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .tx_data  (tx_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int i, input logic lvl, input logic prev);
      logic [7:0] b;
      b    = 8'(i << SH);
      b[2] = prev & ~lvl;
      b[1] = ~prev & lvl;
      b[0] = lvl;
      return b;
   endfunction

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic collect(input logic [N-1:0] snap, input bit stall, input string tag);
      int k = 0;
      int w = 0;
      bit was_stall = 0;
      logic [7:0] held = '0;
      while (k < N && w < 400) begin
         @(negedge clk);
         w++;
         if (was_stall && tx_valid) chk(tx_data == held, "R10 hold", tx_data, held);
         was_stall = 0;
         tx_ready = stall ? ((w % 3) != 0) : 1'b1;
         if (tx_valid && tx_ready) begin
            chk(tx_data == exp_byte(k, snap[k], last_m[k]), tag,
                tx_data, exp_byte(k, snap[k], last_m[k]));
            k++;
         end else if (tx_valid) begin
            held = tx_data;
            was_stall = 1;
         end
      end
      chk(k == N, "R2 byte count", k, N);
      @(negedge clk);
      tx_ready = 1'b0;
      chk(tx_valid == 1'b0, "R2 reply ends after N bytes", tx_valid, 0);
      last_m = snap;
   endtask

   task automatic report(input logic [N-1:0] pat, input logic [7:0] arg, input bit stall,
                         input string tag);
      @(negedge clk);
      probes = pat;
      repeat (3) @(negedge clk);
      send(8'h19);
      send(arg);
      collect(pat, stall, tag);
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(tx_valid == 1'b0, tag, tx_valid, 0);
      end
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] args [4];
      args[0] = 8'h92; args[1] = 8'h80; args[2] = 8'hFF; args[3] = 8'h81;

      repeat (3) @(negedge clk);
      // R12 reset state
      chk(tx_valid == 1'b0, "R12 tx_valid in reset", tx_valid, 0);
      chk(rx_ready == 1'b1, "R12 rx_ready in reset", rx_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_valid == 1'b0, "R12 tx_valid after reset", tx_valid, 0);
      chk(rx_ready == 1'b1, "R12 rx_ready after reset", rx_ready, 1);

      // R3 R4: all low gives the bare index
      report('0, 8'h92, 0, "R3 R4 all low");
      // R5: all rise, then stay high (index plus 0x01)
      report('1, 8'h92, 0, "R5 all rising");
      report('1, 8'h92, 1, "R4 R5 held high");
      // R6: all fall
      report('0, 8'h92, 0, "R6 all falling");

      // R5 R6: walking one over every probe
      for (int i = 0; i < N; i++)
         report(N'(1) << i, 8'h92, i[0], "R5 R6 walking one");

      // R2 R8: pseudo-random patterns with varied count fields
      for (int i = 0; i < 30; i++)
         report(N'($urandom), args[i % 4], i[1], "R2 R4 R5 R6 R8 sweep");

      // R1: argument with bit 7 clear gives nothing
      send(8'h19);
      send(8'h12);
      quiet(10, "R1 bad argument ignored");
      // R1: lone argument byte gives nothing
      send(8'h92);
      quiet(10, "R1 argument without header ignored");
      // R1: repeated header still leads to a reply
      @(negedge clk);
      probes = 18'h2A5C3;
      repeat (3) @(negedge clk);
      send(8'h19);
      send(8'h19);
      send(8'h92);
      collect(18'h2A5C3, 0, "R1 repeated header");

      // R7 R11: change probes and offer a request during a reply
      @(negedge clk);
      probes = 18'h0F0F0;
      repeat (3) @(negedge clk);
      send(8'h19);
      send(8'h92);
      @(negedge clk);
      chk(tx_valid == 1'b1, "R7 reply started", tx_valid, 1);
      chk(rx_ready == 1'b0, "R11 rx_ready low during reply", rx_ready, 0);
      probes = 18'h30F0F;
      rx_valid = 1'b1; rx_data = 8'h19;
      @(negedge clk);
      rx_data = 8'h92;
      @(negedge clk);
      rx_valid = 1'b0;
      collect(18'h0F0F0, 1, "R7 snapshot fixed");
      quiet(10, "R11 no reply from blocked bytes");
      // R8: next reply compares against that snapshot
      report(18'h30F0F, 8'h92, 0, "R8 flags against last reply");

      // R9: change applied before the argument edge is not captured
      @(negedge clk);
      probes = 18'h00000;
      repeat (3) @(negedge clk);
      send(8'h19);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h92; probes = 18'h3FFFF;
      @(negedge clk);
      rx_valid = 1'b0;
      collect(18'h00000, 0, "R9 late change not captured");
      // R9: change applied before the header edge is captured
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h19; probes = 18'h15555;
      @(negedge clk);
      rx_data = 8'h92;
      @(negedge clk);
      rx_valid = 1'b0;
      collect(18'h15555, 0, "R9 early change captured");

      done = 1;
      summary();
      $finish;
   end
endmodule